// File: doc/BRIEF.md
# Configurable 32-Line Interrupt Gatherer

This block collects 32 external interrupt request lines and presents one combined request to a parent processor. Each line passes through a two-flop synchroniser and is then detected in one of four ways, chosen by two per-line configuration bits. A line can fire on a high level, a low level, a rising edge or a falling edge. A detected request is recorded in a status bit. Software can also raise a request through a set register.

Software works through a single-cycle register port. It gives a word address, a write strobe and 32 bits of write data, and read data follows the address combinationally. Software unmasks lines through an enable register and acknowledges requests through a write-one-to-clear register. The combined output is raised while any status bit is set on an enabled line.

Top module: `irq_gather32`

## Requirements
- R1: After reset, enable reads 0, status reads 0, the edge-select register reads 0 and the polarity register reads 0xFFFFFFFF, so every line is level-high. The combined output is low.
- R2: Word address 0 (byte 0x00) is status and is read-only. Word 1 (0x04) is enable. Word 2 (0x08) is set and word 3 (0x0C) is clear; both are write-only and read as 0. Word 4 (0x10) is polarity and word 5 (0x14) is edge-select. Bit n of every register belongs to line n.
- R3: Each line's mode comes from its edge-select bit E and its polarity bit P. E=0,P=1 gives level-high and E=0,P=0 gives level-low. E=1,P=1 gives rising edge and E=1,P=0 gives falling edge.
- R4: In a level mode, the status bit follows the synchronised input after polarity correction. A clear write has no lasting effect while the level is active.
- R5: In an edge mode, a detected edge sets a sticky status bit that stays set until cleared. An input change made before clock edge k appears in status after edge k+2.
- R6: Writing 1 to a bit of the set register forces that line's status to 1, in any mode. The bit stays at 1 until that line is cleared through the clear register.
- R7: The combined output equals the OR over all lines of status AND enable. Unmasking a line that has a pending request raises the output after the write's clock edge.
- R8: Writing zero to enable drops the combined output even while status bits are set.
- R9: Writing 0xFFFFFFFF to the clear register removes every latched edge and software request.
- R10: If a clear and a new edge for the same line take effect on the same clock edge, the edge wins and the status bit stays set.
- R11: Status bits are recorded whether or not the line is enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_in | input | 32 | External interrupt request lines |
| irq_out | output | 1 | Combined request to the parent processor |

## Verification
The assertions assume the register port carries at most one write per cycle. Under that assumption a set and a clear never reach the same line together, and an enable write is the only source of mask change. The assertions also assume the request lines may change at any time, because each line passes through the synchroniser. They do not assume the inputs are stable across mode changes. The stimulus drives writes and input changes only on falling clock edges and never pulses a line faster than the synchroniser can follow. It waits four cycles after each input change before reading, except in the directed latency and same-edge tests, which count edges exactly.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int LINES  = 32;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    RA_STATUS = 3'd0,
    RA_ENABLE = 3'd1,
    RA_SET    = 3'd2,
    RA_CLEAR  = 3'd3,
    RA_POL    = 3'd4,
    RA_TRIG   = 3'd5
  } reg_idx_e;

  // polarity-corrected level: pol=1 means active high
  function automatic logic line_active(input logic lvl, input logic pol);
    return pol ? lvl : ~lvl;
  endfunction

  // transition of the requested direction between prev and cur
  function automatic logic edge_hit(input logic cur, input logic prev, input logic pol);
    return pol ? (cur & ~prev) : (~cur & prev);
  endfunction
endpackage

// File: rtl/irqg_sync.sv
module irqg_sync #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] stage1;
  logic [N-1:0] stage2;

  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= d[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign q = stage2;
endmodule

// File: rtl/irqg_line.sv
module irqg_line
  import irqg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic sync_i,
  input  logic pol_i,
  input  logic trig_i,
  input  logic set_i,
  input  logic clr_i,
  output logic status_o
);
  logic prev_q;
  logic hw_q;
  logic soft_q;
  logic lvl_on;
  logic edge_ev;
  logic hw_d;
  logic soft_d;

  assign lvl_on  = line_active(sync_i, pol_i);
  assign edge_ev = trig_i & edge_hit(sync_i, prev_q, pol_i);

  always_comb begin
    if (trig_i) hw_d = edge_ev | (hw_q & ~clr_i);
    else        hw_d = lvl_on;
    soft_d = set_i | (soft_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      hw_q   <= 1'b0;
      soft_q <= 1'b0;
    end else begin
      prev_q <= sync_i;
      hw_q   <= hw_d;
      soft_q <= soft_d;
    end
  end

  assign status_o = hw_q | soft_q;

  // R5: sticky edge request survives without clear
  a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (trig_i && hw_q && !clr_i) |=> hw_q);
  // R10: detected edge always lands, even against a clear
  a_r10_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    edge_ev |=> status_o);
  // R4: active level is reflected next cycle
  a_r4_level_follow: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig_i && lvl_on) |=> status_o);
  // R6: software set is recorded
  a_r6_soft_set: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> status_o);
endmodule

// File: rtl/irq_gather32.sv
module irq_gather32
  import irqg_pkg::*;
#(
  parameter int NL = LINES,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [NL-1:0] bus_wdata,
  output logic [NL-1:0] bus_rdata,
  input  logic [NL-1:0] irq_in,
  output logic          irq_out
);
  logic [NL-1:0] en_q;
  logic [NL-1:0] pol_q;
  logic [NL-1:0] trig_q;
  logic [NL-1:0] sync_w;
  logic [NL-1:0] status_w;
  logic [NL-1:0] set_vec;
  logic [NL-1:0] clr_vec;
  logic          wr_en;
  logic          wr_pol;
  logic          wr_trig;

  assign wr_en   = bus_wr && (bus_addr == RA_ENABLE);
  assign wr_pol  = bus_wr && (bus_addr == RA_POL);
  assign wr_trig = bus_wr && (bus_addr == RA_TRIG);
  assign set_vec = (bus_wr && (bus_addr == RA_SET))   ? bus_wdata : '0;
  assign clr_vec = (bus_wr && (bus_addr == RA_CLEAR)) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      pol_q  <= '1;
      trig_q <= '0;
    end else begin
      if (wr_en)   en_q   <= bus_wdata;
      if (wr_pol)  pol_q  <= bus_wdata;
      if (wr_trig) trig_q <= bus_wdata;
    end
  end

  irqg_sync #(.N(NL)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (irq_in),
    .q    (sync_w)
  );

  for (genvar i = 0; i < NL; i++) begin : g_line
    irqg_line u_line (
      .clk     (clk),
      .rst_n   (rst_n),
      .sync_i  (sync_w[i]),
      .pol_i   (pol_q[i]),
      .trig_i  (trig_q[i]),
      .set_i   (set_vec[i]),
      .clr_i   (clr_vec[i]),
      .status_o(status_w[i])
    );
  end

  always_comb begin
    case (bus_addr)
      RA_STATUS: bus_rdata = status_w;
      RA_ENABLE: bus_rdata = en_q;
      RA_POL:    bus_rdata = pol_q;
      RA_TRIG:   bus_rdata = trig_q;
      default:   bus_rdata = '0;
    endcase
  end

  assign irq_out = |(status_w & en_q);

  // R8: fully masked controller stays quiet
  a_r8_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == '0) |-> !irq_out);
  // R2: enable write takes the written value
  a_r2_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (en_q == $past(bus_wdata)));
  // R7: software set on an enabled line raises the output next cycle
  a_r7_set_raises: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_vec & en_q) && !wr_en) |=> irq_out);
endmodule

// File: tb/irq_gather32_test.sv
module irq_gather32_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] irq_in = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  localparam logic [2:0] A_ST = 3'd0, A_EN = 3'd1, A_SET = 3'd2,
                         A_CLR = 3'd3, A_POL = 3'd4, A_TRG = 3'd5;

  // {polarity, edge-select, input phase A, input phase B}
  localparam logic [127:0] VEC [6] = '{
    {32'hFFFFFFFF, 32'h00000000, 32'h00000000, 32'h0000FFFF},
    {32'h00000000, 32'h00000000, 32'h00000000, 32'h00FF00FF},
    {32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hFF00FF00},
    {32'h00000000, 32'hFFFFFFFF, 32'h0F0F0F0F, 32'hFF00FF00},
    {32'hFFFF0000, 32'hFF00FF00, 32'hAAAAAAAA, 32'h5555AAAA},
    {32'hA5A5A5A5, 32'h3C3C3C3C, 32'h12345678, 32'h87654321}
  };

  irq_gather32 uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
    .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  // status expected after phase A -> clear -> phase B, from R3/R4/R5
  function automatic logic [31:0] expect_status(input logic [31:0] p, input logic [31:0] e,
                                               input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) begin
      if (e[i]) r[i] = p[i] ? (b[i] && !a[i]) : (!b[i] && a[i]);
      else      r[i] = p[i] ? b[i] : !b[i];
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1 reset state
    rd(A_ST, v);  check("R1 status", v, 32'h0);
    rd(A_EN, v);  check("R1 enable", v, 32'h0);
    rd(A_POL, v); check("R1 polarity", v, 32'hFFFFFFFF);
    rd(A_TRG, v); check("R1 edge-select", v, 32'h0);
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);

    // R3 R4 R5 R11: vector table, enable kept at 0
    for (int k = 0; k < 6; k++) begin
      logic [31:0] p, e, a, b;
      {p, e, a, b} = VEC[k];
      wr(A_POL, p);
      wr(A_TRG, e);
      irq_in = a;
      idle(4);
      wr(A_CLR, 32'hFFFFFFFF);
      irq_in = b;
      idle(4);
      rd(A_ST, v);
      check($sformatf("R3 vector %0d status", k), v, expect_status(p, e, a, b));
      check($sformatf("R11 vector %0d masked out", k), {31'h0, irq_out}, 32'h0);
    end

    // back to level-high, idle inputs
    irq_in = '0;
    wr(A_POL, 32'hFFFFFFFF);
    wr(A_TRG, 32'h0);
    idle(4);
    wr(A_CLR, 32'hFFFFFFFF);
    rd(A_ST, v); check("R9 clean start", v, 32'h0);

    // R2 write-only registers read 0
    wr(A_SET, 32'h00000020);
    rd(A_SET, v); check("R2 set reads 0", v, 32'h0);
    rd(A_CLR, v); check("R2 clear reads 0", v, 32'h0);
    wr(A_ST, 32'h0);
    rd(A_ST, v); check("R6 set forces status, R2 status read-only", v, 32'h00000020);
    check("R11 pending but masked", {31'h0, irq_out}, 32'h0);
    wr(A_EN, 32'h00000020);
    check("R7 unmask raises output", {31'h0, irq_out}, 32'h1);
    wr(A_EN, 32'h0);
    check("R8 zero enable masks", {31'h0, irq_out}, 32'h0);
    wr(A_CLR, 32'h00000020);
    rd(A_ST, v); check("R6 clear removes soft request", v, 32'h0);

    // R4 clear has no lasting effect on active level
    irq_in = 32'h00000008;
    idle(4);
    wr(A_CLR, 32'h00000008);
    rd(A_ST, v); check("R4 level survives clear", v, 32'h00000008);
    irq_in = '0;
    idle(4);
    rd(A_ST, v); check("R4 level released", v, 32'h0);

    // R5 rising edge on line 7: latency and stickiness
    wr(A_TRG, 32'h00000080);
    idle(1);
    irq_in = 32'h00000080;
    idle(2);
    rd(A_ST, v); check("R5 not yet after two edges", v, 32'h0);
    idle(1);
    rd(A_ST, v); check("R5 set after third edge", v, 32'h00000080);
    irq_in = '0;
    idle(4);
    rd(A_ST, v); check("R5 sticky after input falls", v, 32'h00000080);

    // R9 clear-all with edge and soft requests latched
    wr(A_SET, 32'h00010000);
    rd(A_ST, v); check("R9 two requests latched", v, 32'h00010080);
    wr(A_CLR, 32'hFFFFFFFF);
    rd(A_ST, v); check("R9 clear all", v, 32'h0);

    // R10 edge and clear on the same clock edge, line 9
    wr(A_TRG, 32'h00000200);
    idle(1);
    irq_in = 32'h00000200;
    @(negedge clk);
    @(negedge clk);
    bus_addr = A_CLR; bus_wdata = 32'h00000200; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    rd(A_ST, v); check("R10 edge wins over clear", v, 32'h00000200);
    wr(A_CLR, 32'h00000200);
    rd(A_ST, v); check("R10 later clear works", v, 32'h0);
    wr(A_EN, 32'h00000200);
    check("R7 nothing pending", {31'h0, irq_out}, 32'h0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule